// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block receives characters from the slave side of a LIN bus and handles the message header in hardware. It works from the sampled RX line and a 16x oversampling tick, and it reads 8N1 characters, least significant bit first, sampled at the middle of each bit. It recognises a break from how long RX stays low. It times the 0x55 synch field between falling edges, captures the identifier and can check the identifier's two parity bits.

Software picks how headers are signalled. In early mode the header flag rises as soon as the break ends. In late mode the header flag and the receive-full flag rise together, once the identifier has arrived. Auto-resync hides the synch character from the data path. Mute drops ordinary characters, so that only headers are reported. A single clear strobe acknowledges all four flags.

Top module: `lin_hdr_rx`

## Requirements
- R1: A break is recognised when RX has been low for at least 11 bit times (176 ticks) and then returns high. A shorter low run whose data bits are all zero and whose stop bit is zero is reported as a framing error and is not treated as a break.
- R2: In early mode (`hdr_mode`=0), a break loads 0x00 into `rx_data` and sets `rx_full` and `hdr_det`, even in mute.
- R3: In late mode (`hdr_mode`=1), a break sets no flag. `hdr_det` and `rx_full` set together only when the identifier arrives, and `rx_data` then holds the identifier.
- R4: `irq` is high whenever `hdr_det` is set and `hdr_irq_en` is high.
- R5: With `resync_en`=1, the synch character is not written to `rx_data`, and neither `rx_full` nor `frame_err` is set for it, even when its bit length is off nominal.
- R6: With `resync_en`=0, early mode and mute off, the synch character is delivered as an ordinary byte (0x55) and sets `rx_full`. In late mode or in mute it is not delivered.
- R7: `sync_ticks` gives the number of ticks from the first to the fifth falling edge of the synch field, which is 8 bit times (128 at nominal rate).
- R8: The identifier is the third character, counting the break as the first. With `parity_en`=1, bit 6 must equal id0^id1^id2^id4 and bit 7 must equal NOT(id1^id3^id4^id5). A mismatch sets `par_err`. With `parity_en`=0, `par_err` never sets.
- R9: In mute, ordinary characters outside a header leave `rx_data`, `rx_full` and `frame_err` untouched, while headers are still reported.
- R10: Outside a header, a character with a high stop bit is written to `rx_data` and sets `rx_full`. A low stop bit with non-zero data sets `frame_err`.
- R11: A one-cycle `flags_clr` clears `rx_full`, `hdr_det`, `frame_err` and `par_err`.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx | input | 1 | Sampled bus receive line |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| hdr_mode | input | 1 | 0: header flag after break; 1: after identifier |
| resync_en | input | 1 | Hide synch character from the data path |
| parity_en | input | 1 | Check identifier parity bits |
| mute_en | input | 1 | Drop ordinary characters |
| hdr_irq_en | input | 1 | Enable interrupt on header flag |
| flags_clr | input | 1 | Clear all four flags |
| rx_data | output | 8 | Last delivered byte |
| rx_full | output | 1 | Receive-full flag |
| hdr_det | output | 1 | Header-detected flag |
| frame_err | output | 1 | Framing error, breaks excluded |
| par_err | output | 1 | Identifier parity error |
| irq | output | 1 | Header interrupt |
| sync_ticks | output | SYNC_W | Measured synch duration in ticks |

## Verification
The hardest case to reach is a synch field sent off the nominal rate with auto-resync on. The character sampler then decodes garbage or sees a low stop bit in the middle of the header, and that event must be swallowed while the identifier that follows must still line up. The stimulus draws the synch bit length at random from 14 to 18 ticks, leaves an inter-byte gap after it, and checks both the measured duration and the absence of any flag. Directed runs hold RX low for 175 and then 176 ticks to pin down the exact break threshold.

// File: rtl/lin_rx_pkg.sv
// Shared types and helpers for the LIN slave header receiver.
// Assumes 8-bit identifiers: 6 id bits plus 2 parity bits on top.
package lin_rx_pkg;

    // character sampler states
    typedef enum logic [2:0] {
        CR_IDLE,
        CR_START,
        CR_DATA,
        CR_WAITHI
    } chr_st_t;

    // header sequencing states
    typedef enum logic [1:0] {
        HS_NORM,
        HS_SYNC,
        HS_SYNC_END,
        HS_ID
    } hdr_st_t;

    // identifier parity: bit6 = even parity of id0,1,2,4; bit7 = odd parity of id1,3,4,5
    function automatic logic id_par_ok(input logic [7:0] f);
        logic p0;
        logic p1;
        p0 = f[0] ^ f[1] ^ f[2] ^ f[4];
        p1 = ~(f[1] ^ f[3] ^ f[4] ^ f[5]);
        return (f[6] == p0) && (f[7] == p1);
    endfunction

endpackage

// File: rtl/lin_char_rx.sv
// 8N1 character sampler with break recognition.
// Samples RX only on the oversampling tick and assumes RX is already
// synchronised. Emits one-cycle events: a good character, a framing
// error, or a break (an all-zero character whose low run reached
// BRK_BITS bit times before RX returned high).
module lin_char_rx
    import lin_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    output logic       ev_char,
    output logic       ev_fe,
    output logic       ev_brk,
    output logic [7:0] ev_data
);
    localparam int CW        = $clog2(OSR);
    localparam int BRK_TICKS = OSR * BRK_BITS;
    localparam int LW        = $clog2(BRK_TICKS) + 2;
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
    localparam logic [LW-1:0] BRK_MIN  = LW'(BRK_TICKS);

    chr_st_t       st;
    logic [CW-1:0] cnt;
    logic [3:0]    bitn;
    logic [7:0]    shreg;
    logic          brk_cand;
    logic [LW-1:0] low_run;

    assign ev_data = shreg;

    // count consecutive low ticks on RX, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (tick) begin
            if (rx)
                low_run <= '0;
            else if (low_run != '1)
                low_run <= low_run + 1'b1;
        end
    end

    // framing state machine: start check, 8 data bits, stop, wait for idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= CR_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            shreg    <= '0;
            brk_cand <= 1'b0;
            ev_char  <= 1'b0;
            ev_fe    <= 1'b0;
            ev_brk   <= 1'b0;
        end else begin
            ev_char <= 1'b0;
            ev_fe   <= 1'b0;
            ev_brk  <= 1'b0;
            if (tick) begin
                case (st)
                    CR_IDLE: begin
                        if (!rx) begin
                            st  <= CR_START;
                            cnt <= '0;
                        end
                    end
                    CR_START: begin
                        if (cnt == MID_CNT) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= rx ? CR_IDLE : CR_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    CR_DATA: begin
                        if (cnt == LAST_CNT) begin
                            cnt <= '0;
                            if (bitn == 4'd8) begin
                                if (rx) begin
                                    ev_char <= 1'b1;
                                    st      <= CR_IDLE;
                                end else if (shreg == 8'h00) begin
                                    brk_cand <= 1'b1;
                                    st       <= CR_WAITHI;
                                end else begin
                                    ev_fe    <= 1'b1;
                                    brk_cand <= 1'b0;
                                    st       <= CR_WAITHI;
                                end
                            end else begin
                                shreg <= {rx, shreg[7:1]};
                                bitn  <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    CR_WAITHI: begin
                        if (rx) begin
                            st <= CR_IDLE;
                            if (brk_cand) begin
                                if (low_run >= BRK_MIN)
                                    ev_brk <= 1'b1;
                                else
                                    ev_fe <= 1'b1;
                            end
                        end
                    end
                    default: st <= CR_IDLE;
                endcase
            end
        end
    end

    // at most one event per cycle
    assert_evt_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_char, ev_fe, ev_brk}));

    // a break is only declared once RX has come back high
    assert_brk_on_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_brk |-> $past(rx));

endmodule

// File: rtl/lin_sync_meter.sv
// Synch field timer. Armed by a break; counts ticks from the first
// falling RX edge to the FALL_EDGES-th one and holds the result.
// Assumes the line is high when armed (break delimiter).
module lin_sync_meter #(
    parameter int SYNC_W     = 9,
    parameter int FALL_EDGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              arm,
    output logic              done,
    output logic [SYNC_W-1:0] sync_ticks
);
    localparam int EW = $clog2(FALL_EDGES + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(FALL_EDGES - 1);

    logic              rx_prev;
    logic              armed;
    logic [EW-1:0]     edges;
    logic [SYNC_W-1:0] cnt;

    // edge counting and duration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev    <= 1'b1;
            armed      <= 1'b0;
            edges      <= '0;
            cnt        <= '0;
            done       <= 1'b0;
            sync_ticks <= '0;
        end else begin
            done <= 1'b0;
            if (tick)
                rx_prev <= rx;
            if (arm) begin
                armed <= 1'b1;
                edges <= '0;
                cnt   <= '0;
            end else if (tick && armed) begin
                if (edges != '0 && cnt != '1)
                    cnt <= cnt + 1'b1;
                if (rx_prev && !rx) begin
                    edges <= edges + 1'b1;
                    if (edges == '0)
                        cnt <= '0;
                    if (edges == LAST_EDGE) begin
                        sync_ticks <= cnt + 1'b1;
                        done       <= 1'b1;
                        armed      <= 1'b0;
                    end
                end
            end
        end
    end

    // the published duration only moves when a measurement completes
    assert_ticks_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_ticks) |-> done);

    // a completed measurement leaves the meter disarmed
    assert_done_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !armed);

endmodule

// File: rtl/lin_hdr_fsm.sv
// Header sequencer and flag registers. Consumes sampler events and the
// synch-meter completion, walks break -> synch -> identifier, and
// decides which bytes reach the data register and which flags rise.
// Assumes the synch measurement finishes before the synch character's
// own sampler event (true for rates within a few percent of nominal).
module lin_hdr_fsm
    import lin_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_char,
    input  logic          ev_fe,
    input  logic          ev_brk,
    input  logic [DW-1:0] ev_data,
    input  logic          meas_done,
    input  logic          hdr_mode,
    input  logic          resync_en,
    input  logic          parity_en,
    input  logic          mute_en,
    input  logic          flags_clr,
    output logic          meter_arm,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          hdr_det,
    output logic          frame_err,
    output logic          par_err
);
    hdr_st_t       st, nxt;
    logic          ld;
    logic [DW-1:0] ld_val;
    logic          s_full, s_hdr, s_fe, s_pe;

    // next state and flag-set decisions for this cycle
    always_comb begin
        nxt       = st;
        ld        = 1'b0;
        ld_val    = ev_data;
        s_full    = 1'b0;
        s_hdr     = 1'b0;
        s_fe      = 1'b0;
        s_pe      = 1'b0;
        meter_arm = 1'b0;
        if (ev_brk) begin
            nxt       = HS_SYNC;
            meter_arm = 1'b1;
            if (!hdr_mode) begin
                ld     = 1'b1;
                ld_val = '0;
                s_full = 1'b1;
                s_hdr  = 1'b1;
            end
        end else begin
            case (st)
                HS_NORM: begin
                    if (ev_char && !mute_en) begin
                        ld     = 1'b1;
                        s_full = 1'b1;
                    end
                    if (ev_fe && !mute_en)
                        s_fe = 1'b1;
                end
                HS_SYNC: begin
                    if (meas_done)
                        nxt = HS_SYNC_END;
                end
                HS_SYNC_END: begin
                    if (ev_char || ev_fe) begin
                        nxt = HS_ID;
                        if (!resync_en && !hdr_mode && !mute_en) begin
                            ld     = ev_char;
                            s_full = ev_char;
                            s_fe   = ev_fe;
                        end
                    end
                end
                HS_ID: begin
                    if (ev_char) begin
                        nxt    = HS_NORM;
                        ld     = 1'b1;
                        s_full = 1'b1;
                        s_hdr  = hdr_mode;
                        s_pe   = parity_en && !id_par_ok(ev_data);
                    end else if (ev_fe) begin
                        nxt  = HS_NORM;
                        s_fe = 1'b1;
                    end
                end
                default: nxt = HS_NORM;
            endcase
        end
    end

    // state, data register and sticky flags (set beats clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= HS_NORM;
            rx_data   <= '0;
            rx_full   <= 1'b0;
            hdr_det   <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
        end else begin
            st <= nxt;
            if (ld)
                rx_data <= ld_val;
            rx_full   <= s_full | (rx_full   & !flags_clr);
            hdr_det   <= s_hdr  | (hdr_det   & !flags_clr);
            frame_err <= s_fe   | (frame_err & !flags_clr);
            par_err   <= s_pe   | (par_err   & !flags_clr);
        end
    end

    // early mode: a break leaves 0x00 with both flags up
    assert_brk_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_brk && !hdr_mode |=> rx_full && hdr_det && (rx_data == '0));

    // late mode: the header flag rises only on identifier completion
    assert_late_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_det) && hdr_mode |-> $past(st) == HS_ID);

    // resync on: nothing is delivered while the synch field is in flight
    assert_sync_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HS_SYNC || st == HS_SYNC_END) && resync_en && !ev_brk
        |=> !$rose(rx_full) && !$rose(frame_err));

    // mute: ordinary characters raise nothing
    assert_mute_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st == HS_NORM && mute_en && !ev_brk |=> !$rose(rx_full) && !$rose(frame_err));

    // parity check off: the parity flag cannot rise on an identifier
    assert_par_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st == HS_ID && ev_char && !parity_en |=> !$rose(par_err));

endmodule

// File: rtl/lin_hdr_rx.sv
// LIN slave header receiver top. Ties the character sampler, the
// synch meter and the header sequencer together and forms the
// interrupt. Assumes RX is synchronised and os_tick pulses for one
// clock at OSR times the bit rate.
module lin_hdr_rx #(
    parameter int OSR      = 16,
    parameter int BRK_BITS = 11,
    parameter int SYNC_W   = $clog2(OSR * 16) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx,
    input  logic              os_tick,
    input  logic              hdr_mode,
    input  logic              resync_en,
    input  logic              parity_en,
    input  logic              mute_en,
    input  logic              hdr_irq_en,
    input  logic              flags_clr,
    output logic [7:0]        rx_data,
    output logic              rx_full,
    output logic              hdr_det,
    output logic              frame_err,
    output logic              par_err,
    output logic              irq,
    output logic [SYNC_W-1:0] sync_ticks
);
    localparam int SYNC_FALLS = 5;

    logic       ev_char, ev_fe, ev_brk;
    logic [7:0] ev_data;
    logic       meas_done, meter_arm;

    lin_char_rx #(.OSR(OSR), .BRK_BITS(BRK_BITS)) u_chr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .rx      (rx),
        .ev_char (ev_char),
        .ev_fe   (ev_fe),
        .ev_brk  (ev_brk),
        .ev_data (ev_data)
    );

    lin_sync_meter #(.SYNC_W(SYNC_W), .FALL_EDGES(SYNC_FALLS)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .rx         (rx),
        .arm        (meter_arm),
        .done       (meas_done),
        .sync_ticks (sync_ticks)
    );

    lin_hdr_fsm #(.DW(8)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_char   (ev_char),
        .ev_fe     (ev_fe),
        .ev_brk    (ev_brk),
        .ev_data   (ev_data),
        .meas_done (meas_done),
        .hdr_mode  (hdr_mode),
        .resync_en (resync_en),
        .parity_en (parity_en),
        .mute_en   (mute_en),
        .flags_clr (flags_clr),
        .meter_arm (meter_arm),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .hdr_det   (hdr_det),
        .frame_err (frame_err),
        .par_err   (par_err)
    );

    // interrupt follows the header flag when enabled
    assign irq = hdr_det & hdr_irq_en;

endmodule

// File: tb/sim_lin_hdr_rx.sv
// Bench: directed corner cases, then seeded random headers and bytes.
module sim_lin_hdr_rx;
    localparam int OSR = 16;
    localparam int WD_CYCLES = 190000;

    logic       clk = 1'b0, rst_n = 1'b0, rx = 1'b1, os_tick = 1'b0;
    logic       hdr_mode = 1'b0, resync_en = 1'b0, parity_en = 1'b0;
    logic       mute_en = 1'b0, hdr_irq_en = 1'b0, flags_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, hdr_det, frame_err, par_err, irq;
    logic [8:0] sync_ticks;
    int         n_chk = 0, n_bad = 0;
    bit         ended = 1'b0;

    lin_hdr_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx(rx), .os_tick(os_tick),
        .hdr_mode(hdr_mode), .resync_en(resync_en), .parity_en(parity_en),
        .mute_en(mute_en), .hdr_irq_en(hdr_irq_en), .flags_clr(flags_clr),
        .rx_data(rx_data), .rx_full(rx_full), .hdr_det(hdr_det),
        .frame_err(frame_err), .par_err(par_err), .irq(irq),
        .sync_ticks(sync_ticks)
    );

    always #10 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    function automatic bit par_good(input logic [7:0] f);
        return (f[6] == (f[0] ^ f[1] ^ f[2] ^ f[4])) &&
               (f[7] == !(f[1] ^ f[3] ^ f[4] ^ f[5]));
    endfunction

    function automatic logic [7:0] make_id(input logic [5:0] raw, input bit spoil);
        logic [7:0] f;
        f = {!(raw[1] ^ raw[3] ^ raw[4] ^ raw[5]), raw[0] ^ raw[1] ^ raw[2] ^ raw[4], raw};
        if (spoil) f[6 + ($urandom % 2)] ^= 1'b1;
        return f;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // hold RX at a level for n oversampling ticks
    task automatic hold(input logic lvl, input int n);
        rx = lvl;
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int len, input logic stopv);
        hold(1'b0, len);
        for (int i = 0; i < 8; i++) hold(b[i], len);
        hold(stopv, len);
        hold(1'b1, 2 * OSR);
    endtask

    task automatic clr();
        flags_clr = 1'b1;
        @(negedge clk);
        flags_clr = 1'b0;
    endtask

    // full header with checks after each field
    task automatic do_header(input int brk, input int ls, input logic [7:0] id);
        bit sync_del;
        clr();
        hold(1'b0, brk);
        hold(1'b1, OSR);
        if (!hdr_mode) begin
            check("R2", "break data", rx_data, 0);
            check("R2", "break rx_full", rx_full, 1);
            check("R2", "break hdr_det", hdr_det, 1);
            check("R4", "irq after break", irq, hdr_irq_en);
        end else begin
            check("R3", "break rx_full", rx_full, 0);
            check("R3", "break hdr_det", hdr_det, 0);
            check("R4", "irq after late break", irq, 0);
        end
        check("R1", "break no frame_err", frame_err, 0);
        clr();
        send_byte(8'h55, ls, 1'b1);
        sync_del = !resync_en && !hdr_mode && !mute_en;
        check(resync_en ? "R5" : "R6", "synch rx_full", rx_full, sync_del);
        if (sync_del) check("R6", "synch data", rx_data, 8'h55);
        check("R5", "synch frame_err", frame_err, 0);
        check("R7", "sync_ticks", sync_ticks, 8 * ls);
        clr();
        send_byte(id, OSR, 1'b1);
        check("R8", "id data", rx_data, id);
        check("R8", "id rx_full", rx_full, 1);
        check("R3", "id hdr_det", hdr_det, hdr_mode);
        check("R8", "par_err", par_err, parity_en && !par_good(id));
        check("R4", "irq after id", irq, hdr_mode && hdr_irq_en);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=finish before", WD_CYCLES);
        report();
    end

    initial begin
        void'($urandom(32'h5EED_1A7));
        repeat (4) @(negedge clk);
        // R12 reset state
        check("R12", "reset rx_data", rx_data, 0);
        check("R12", "reset flags", {rx_full, hdr_det, frame_err, par_err, irq}, 0);
        check("R12", "reset sync_ticks", sync_ticks, 0);
        rst_n = 1'b1;
        hold(1'b1, 4 * OSR);

        hdr_irq_en = 1'b1; parity_en = 1'b1; resync_en = 1'b1;
        // R10 ordinary byte and bad stop
        send_byte(8'hA5, OSR, 1'b1);
        check("R10", "char data", rx_data, 8'hA5);
        check("R10", "char rx_full", rx_full, 1);
        send_byte(8'h3C, OSR, 1'b0);
        check("R10", "bad stop frame_err", frame_err, 1);
        check("R10", "bad stop data kept", rx_data, 8'hA5);
        // R11 clear
        clr();
        check("R11", "clear flags", {rx_full, hdr_det, frame_err, par_err}, 0);
        // R1 boundary: one tick short of a break
        hold(1'b0, 11 * OSR - 1);
        hold(1'b1, 2 * OSR);
        check("R1", "short low frame_err", frame_err, 1);
        check("R1", "short low hdr_det", hdr_det, 0);
        // R1 boundary: exactly eleven bit times
        do_header(11 * OSR, OSR, make_id(6'h2B, 1'b0));
        // R9 mute with a header in early mode
        mute_en = 1'b1;
        do_header(13 * OSR, OSR, make_id(6'h11, 1'b1));
        clr();
        send_byte(8'h9E, OSR, 1'b1);
        check("R9", "mute rx_full", rx_full, 0);

        for (int it = 0; it < 40; it++) begin
            logic [7:0] id, b;
            int ls;
            hdr_mode   = $urandom % 2;
            resync_en  = $urandom % 2;
            parity_en  = $urandom % 2;
            mute_en    = ($urandom % 3) == 0;
            hdr_irq_en = $urandom % 2;
            ls  = resync_en ? 14 + ($urandom % 5) : OSR;
            id  = make_id(6'($urandom), ($urandom % 4) == 0);
            do_header(13 * OSR, ls, id);
            clr();
            b = 8'($urandom);
            send_byte(b, OSR, 1'b1);
            if (mute_en) begin
                check("R9", "mute char rx_full", rx_full, 0);
                check("R9", "mute char data kept", rx_data, id);
            end else begin
                check("R10", "random char data", rx_data, b);
                check("R10", "random char rx_full", rx_full, 1);
            end
            clr();
            send_byte(8'($urandom) | 8'h01, OSR, 1'b0);
            check(mute_en ? "R9" : "R10", "bad stop frame_err", frame_err, !mute_en);
        end
        report();
    end
endmodule